// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles which directions of PAUSE-based flow control a MAC should use once the link is up. It takes the pause and asymmetric-direction advertisement bits of the local port and of the link partner, the mode that software asked for and the negotiated duplex, and turns them into two registered control lines: one lets the MAC send PAUSE frames, the other lets it honour received ones.

Two strobes start an update. A resolve strobe runs the negotiation rules, but only while auto-negotiation is enabled and reported complete. A force strobe applies the software request directly, and only while auto-negotiation is disabled. An accepted update lands on the clock edge that samples the strobe and is marked by a one-cycle done pulse; a request code outside the defined set raises a one-cycle configuration error pulse instead and leaves the controls untouched. All pins are plain control and status levels or strobes; there is no streaming interface and no back-pressure.

Top module: `pause_fc_resolver`

## Requirements
- R1: While reset is asserted, and after release until the first accepted update, both enables, the done pulse and the error pulse are 0.
- R2: On an accepted resolve with full duplex and both pause bits set (local and partner), the mode is full if the request is 3 or 4, and receive-only for requests 0, 1 and 2; the asymmetric bits play no part.
- R3: On an accepted resolve with full duplex, local pause 0 and asymmetric 1 with partner pause 1 and asymmetric 1 gives transmit-only.
- R4: On an accepted resolve with full duplex, local pause 1 and asymmetric 1 with partner pause 0 and asymmetric 1 gives receive-only.
- R5: On an accepted resolve with full duplex, every advertisement combination not covered by R2 to R4 gives none.
- R6: On an accepted resolve with half duplex (full_duplex = 0), the mode is none whatever the advertisements and request.
- R7: Mode codes are 0 none, 1 receive-only, 2 transmit-only, 3 full, and request code 4 means default and acts as full; rx_pause_en is bit 0 of the mode and tx_pause_en is bit 1.
- R8: A strobe that would be accepted but carries request code 5, 6 or 7 pulses cfg_err for one cycle, gives no done pulse and leaves both enables unchanged.
- R9: A resolve strobe while autoneg_en or an_complete is 0 is ignored: enables hold and neither done nor cfg_err pulses.
- R10: A force strobe while autoneg_en is 0 loads the requested mode directly, ignoring advertisements and duplex; while autoneg_en is 1 a force strobe is ignored.
- R11: An accepted update changes the enables on the clock edge that samples the strobe, with done high for exactly the following cycle; without a further strobe, the enables then hold.
- R12: When both strobes arrive in the same cycle, autoneg_en alone decides which one may act, and the other has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| autoneg_en | input | 1 | Auto-negotiation enabled |
| an_complete | input | 1 | Auto-negotiation finished |
| full_duplex | input | 1 | 1 = negotiated full duplex, 0 = half |
| loc_pause | input | 1 | Local symmetric pause advertisement |
| loc_asym | input | 1 | Local asymmetric direction advertisement |
| lp_pause | input | 1 | Partner symmetric pause advertisement |
| lp_asym | input | 1 | Partner asymmetric direction advertisement |
| req_mode | input | 3 | Requested mode code (0..4 legal) |
| resolve_stb | input | 1 | One-cycle strobe: resolve from advertisements |
| force_stb | input | 1 | One-cycle strobe: apply request directly |
| tx_pause_en | output | 1 | MAC may transmit PAUSE frames |
| rx_pause_en | output | 1 | MAC acts on received PAUSE frames |
| done | output | 1 | One-cycle pulse: controls updated |
| cfg_err | output | 1 | One-cycle pulse: illegal request code |

## Verification
The two functions that can meet in one cycle are negotiated resolution and forced application: the bench raises both strobes together, once with autoneg_en high and once low, and with an illegal request in the same cycle, and a per-clock reference model decides which one (if any) may act. A second collision is an illegal request arriving on a strobe that would otherwise have been accepted; the model expects the error pulse, no done and held enables. Every advertisement combination is swept under a full request and the request code is varied with symmetric advertisements, so the interplay of request and table is judged cycle by cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FC_OFF  = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_BOTH = 2'd3
  } fc_mode_e;

  typedef struct packed {
    logic pause;
    logic asym;
  } adv_t;

  localparam int CTRL_BITS = 2;

endpackage

// File: rtl/pfc_req_decode.sv
module pfc_req_decode
  import pfc_pkg::*;
#(
  parameter int REQ_W = 3
) (
  input  logic [REQ_W-1:0] req,
  output fc_mode_e         mode,
  output logic             legal
);
  localparam logic [REQ_W-1:0] LAST_DIRECT = REQ_W'(3);
  localparam logic [REQ_W-1:0] AUTO_CODE   = REQ_W'(4);

  always_comb begin
    legal = 1'b1;
    mode  = FC_OFF;
    if (req <= LAST_DIRECT) begin
      mode = fc_mode_e'(req[1:0]);
    end else if (req == AUTO_CODE) begin
      mode = FC_BOTH;
    end else begin
      legal = 1'b0;
    end
  end
endmodule

// File: rtl/pfc_adv_resolve.sv
module pfc_adv_resolve
  import pfc_pkg::*;
(
  input  adv_t     loc,
  input  adv_t     lp,
  input  fc_mode_e want,
  input  logic     full_dup,
  output fc_mode_e mode
);
  logic sym_both, tx_only, rx_only;

  assign sym_both = loc.pause & lp.pause;
  assign tx_only  = ~loc.pause & loc.asym & lp.pause & lp.asym;
  assign rx_only  = loc.pause & loc.asym & ~lp.pause & lp.asym;

  always_comb begin
    if (sym_both) begin
      mode = (want == FC_BOTH) ? FC_BOTH : FC_RX;
    end else if (tx_only) begin
      mode = FC_TX;
    end else if (rx_only) begin
      mode = FC_RX;
    end else begin
      mode = FC_OFF;
    end
    if (!full_dup) mode = FC_OFF;
  end
endmodule

// File: rtl/pfc_ctrl_reg.sv
module pfc_ctrl_reg
  import pfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     bad,
  input  fc_mode_e mode_in,
  output logic     tx_en,
  output logic     rx_en,
  output logic     done,
  output logic     err
);
  logic [CTRL_BITS-1:0] bits_q;

  for (genvar i = 0; i < CTRL_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bits_q[i] <= 1'b0;
      else if (load) bits_q[i] <= mode_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= load;
      err  <= bad;
    end
  end

  assign rx_en = bits_q[0];
  assign tx_en = bits_q[1];
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pfc_pkg::*;
#(
  parameter int REQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             autoneg_en,
  input  logic             an_complete,
  input  logic             full_duplex,
  input  logic             loc_pause,
  input  logic             loc_asym,
  input  logic             lp_pause,
  input  logic             lp_asym,
  input  logic [REQ_W-1:0] req_mode,
  input  logic             resolve_stb,
  input  logic             force_stb,
  output logic             tx_pause_en,
  output logic             rx_pause_en,
  output logic             done,
  output logic             cfg_err
);
  fc_mode_e req_dec, neg_mode, next_mode;
  logic     req_ok, res_go, frc_go, any_go;
  adv_t     loc_adv, lp_adv;

  assign loc_adv = '{pause: loc_pause, asym: loc_asym};
  assign lp_adv  = '{pause: lp_pause,  asym: lp_asym};

  pfc_req_decode #(.REQ_W(REQ_W)) u_dec (
    .req   (req_mode),
    .mode  (req_dec),
    .legal (req_ok)
  );

  pfc_adv_resolve u_res (
    .loc      (loc_adv),
    .lp       (lp_adv),
    .want     (req_dec),
    .full_dup (full_duplex),
    .mode     (neg_mode)
  );

  // Resolve needs negotiation on and finished; force needs it off.
  assign res_go    = resolve_stb & autoneg_en & an_complete;
  assign frc_go    = force_stb & ~autoneg_en;
  assign any_go    = res_go | frc_go;
  assign next_mode = frc_go ? req_dec : neg_mode;

  pfc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (any_go & req_ok),
    .bad     (any_go & ~req_ok),
    .mode_in (next_mode),
    .tx_en   (tx_pause_en),
    .rx_en   (rx_pause_en),
    .done    (done),
    .err     (cfg_err)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int REQ_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             autoneg_en,
  input logic             an_complete,
  input logic             full_duplex,
  input logic             loc_pause,
  input logic             loc_asym,
  input logic             lp_pause,
  input logic             lp_asym,
  input logic [REQ_W-1:0] req_mode,
  input logic             resolve_stb,
  input logic             force_stb,
  input logic             tx_pause_en,
  input logic             rx_pause_en,
  input logic             done,
  input logic             cfg_err
);
  logic acts, legal_req;
  assign acts      = (resolve_stb & autoneg_en & an_complete) | (force_stb & ~autoneg_en);
  assign legal_req = (req_mode <= REQ_W'(4));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acts |=> ($stable(tx_pause_en) && $stable(rx_pause_en) && !done && !cfg_err));

  a_r8_err_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (acts && !legal_req) |=> (cfg_err && !done && $stable(tx_pause_en) && $stable(rx_pause_en)));

  a_r8_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cfg_err));

  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acts && legal_req) |=> done);

  a_r6_half_off: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_stb && autoneg_en && an_complete && legal_req && !full_duplex)
      |=> (!tx_pause_en && !rx_pause_en));

  a_r5_no_adv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_stb && autoneg_en && an_complete && legal_req && !loc_pause && !loc_asym)
      |=> (!tx_pause_en && !rx_pause_en));

  a_r10_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && autoneg_en && !(resolve_stb && an_complete))
      |=> ($stable(tx_pause_en) && $stable(rx_pause_en)));
endmodule

bind pause_fc_resolver pfc_checker #(.REQ_W(REQ_W)) u_chk (.*);

// File: tb/sim_pause_fc_resolver.sv
module sim_pause_fc_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic autoneg_en = 1'b0, an_complete = 1'b0, full_duplex = 1'b1;
  logic loc_pause = 1'b0, loc_asym = 1'b0, lp_pause = 1'b0, lp_asym = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic resolve_stb = 1'b0, force_stb = 1'b0;
  logic tx_pause_en, rx_pause_en, done, cfg_err;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // reference state
  logic m_tx = 1'b0, m_rx = 1'b0, m_done = 1'b0, m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_fc_resolver u0 (
    .clk(clk), .rst_n(rst_n), .autoneg_en(autoneg_en), .an_complete(an_complete),
    .full_duplex(full_duplex), .loc_pause(loc_pause), .loc_asym(loc_asym),
    .lp_pause(lp_pause), .lp_asym(lp_asym), .req_mode(req_mode),
    .resolve_stb(resolve_stb), .force_stb(force_stb),
    .tx_pause_en(tx_pause_en), .rx_pause_en(rx_pause_en), .done(done), .cfg_err(cfg_err)
  );

  // Negotiated outcome as {tx, rx}, written from the rule list.
  function automatic logic [1:0] negotiate(logic lpz, logic laz, logic ppz, logic paz,
                                           int req, logic fd);
    logic [1:0] r;
    case ({lpz, laz, ppz, paz})
      4'b0111: r = 2'b10;
      4'b1101: r = 2'b01;
      default: r = 2'b00;
    endcase
    if (lpz && ppz) r = (req == 3 || req == 4) ? 2'b11 : 2'b01;
    if (!fd) r = 2'b00;
    return r;
  endfunction

  task automatic chk(string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    logic rg, fg;
    logic [1:0] m;
    int r;
    @(posedge clk);
    r  = int'(req_mode);
    rg = resolve_stb && autoneg_en && an_complete;
    fg = force_stb && !autoneg_en;
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (rg || fg) begin
        if (r > 4) m_err = 1;
        else begin
          m_done = 1;
          if (fg) m = (r == 4) ? 2'b11 : 2'(r[1:0] == 2'd1 ? 2'b01 : (r == 2 ? 2'b10 : (r == 3 ? 2'b11 : 2'b00)));
          else    m = negotiate(loc_pause, loc_asym, lp_pause, lp_asym, r, full_duplex);
          m_tx = m[1]; m_rx = m[0];
        end
      end
    end
    #1;
    chk("tx_pause_en", tx_pause_en, m_tx);
    chk("rx_pause_en", rx_pause_en, m_rx);
    chk("done", done, m_done);
    chk("cfg_err", cfg_err, m_err);
  endtask

  task automatic go(string tag, logic an, logic cmp, logic fd, logic [3:0] adv,
                    int req, logic rs, logic fs);
    cur_req = tag;
    autoneg_en = an; an_complete = cmp; full_duplex = fd;
    {loc_pause, loc_asym, lp_pause, lp_asym} = adv;
    req_mode = 3'(req); resolve_stb = rs; force_stb = fs;
    cyc();
    resolve_stb = 0; force_stb = 0;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    #2;
    chk("tx_pause_en", tx_pause_en, 1'b0);
    chk("rx_pause_en", rx_pause_en, 1'b0);
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (2) cyc();

    // R11: force full, check timing of update and done, then hold
    go("R11", 0, 0, 1, 4'b0000, 3, 0, 1);
    cur_req = "R11"; repeat (2) cyc();

    // Sweep every advertisement pattern under a full request
    for (int k = 0; k < 16; k++) begin
      string t;
      if (k[3] && k[1])   t = "R2";
      else if (k == 4'b0111) t = "R3";
      else if (k == 4'b1101) t = "R4";
      else t = "R5";
      go(t, 1, 1, 1, 4'(k), 3, 1, 0);
    end

    // R2: request decides between full and receive-only
    go("R2", 1, 1, 1, 4'b1010, 1, 1, 0);
    go("R2", 1, 1, 1, 4'b1111, 2, 1, 0);
    go("R2", 1, 1, 1, 4'b1010, 0, 1, 0);
    go("R7", 1, 1, 1, 4'b1111, 4, 1, 0);

    // R6: half duplex forces none
    go("R6", 1, 1, 0, 4'b1111, 3, 1, 0);
    go("R6", 1, 1, 1, 4'b0111, 3, 1, 0);
    go("R6", 1, 1, 0, 4'b0111, 3, 1, 0);

    // R9: resolve ignored when negotiation incomplete or off
    go("R2", 1, 1, 1, 4'b1111, 3, 1, 0);
    go("R9", 1, 0, 1, 4'b0000, 3, 1, 0);
    go("R9", 0, 1, 1, 4'b0000, 3, 1, 0);

    // R10 and R7: forced modes
    for (int q = 0; q < 5; q++) go("R7", 0, 0, 0, 4'b0000, q, 0, 1);
    go("R10", 0, 0, 0, 4'b1111, 1, 0, 1);
    go("R10", 1, 0, 1, 4'b0000, 2, 0, 1);

    // R8: illegal codes on both paths
    go("R8", 0, 0, 1, 4'b0000, 5, 0, 1);
    go("R8", 1, 1, 1, 4'b0000, 6, 1, 0);
    go("R8", 1, 1, 1, 4'b1111, 7, 1, 0);
    go("R8", 1, 0, 1, 4'b0000, 7, 1, 0);

    // R12: both strobes together
    go("R12", 1, 1, 1, 4'b0111, 3, 1, 1);
    go("R12", 0, 1, 1, 4'b0000, 1, 1, 1);
    go("R12", 1, 0, 1, 4'b0000, 2, 1, 1);
    go("R12", 0, 1, 1, 4'b0000, 6, 1, 1);

    // R11: back-to-back strobes
    cur_req = "R11";
    autoneg_en = 0; req_mode = 3'd2; force_stb = 1; cyc();
    req_mode = 3'd1; cyc();
    force_stb = 0; cyc(); cyc();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule